// File: doc/BRIEF.md
# Serial Management Register Slave (Strobe-Driven)

This block plays the PHY side of an MII management exchange for a single PHY. The host does not toggle a free-running management clock pin. It writes a 32-bit control word, and each write counts as one clock pulse when its command bits form one of two exact patterns. A "feed" word delivers one bit to a frame decoder. A "pop" word moves one bit of read data into a returned-data bit of the control image, which the host then reads back.

The decoder follows the usual management frame. Idle ones act as preamble. A 0 followed by a 1 marks the start. Two opcode bits select a read or a write. Five PHY-address bits come next, then five register-address bits, both MSB first. A read loads the addressed 16-bit value into a 32-bit output shifter with a leading dummy zero. A write needs a 1-then-0 turnaround and then takes sixteen data bits. Storage is a 32 x 16 register file that every PHY address shares. A read of the basic status register returns a link indication taken from an input pin, not the stored contents.

Top module: `mii_mgmt_slave`

## Requirements
- R1: After synchronous reset, ctl_q is zero, the output shifter is empty (the first pop returns 0), and all 32 stored registers read as 0x0000.
- R2: A write feeds the decoder only when the word, with bit 17 masked off, equals exactly bit 16 (clock) plus bit 13 (write enable), i.e. 0x0001_2000. Bit 17 is then the fed bit. Any other word, such as one with an extra bit set or with the clock bit missing, leaves the decoder unchanged.
- R3: A write whose word, with bit 17 masked off, equals exactly bits 16, 14 and 18 (0x0005_4000) is a pop. It stores the word into ctl_q with bit 19 replaced by the current MSB of the output shifter. A non-pop write with bit 19 set stores bit 19 as written.
- R4: In idle, 1 bits are ignored and a 0 moves to a sync state. There a 1 completes the start and a 0 returns to idle.
- R5: After the start, opcode bits 1,0 select read and 0,1 select write. The patterns 1,1 and 0,0 return to idle.
- R6: PHY address and register address are each 5 bits, MSB first. The PHY address does not select storage, so any PHY address reaches the same register.
- R7: When the last register-address bit of a read arrives, the read value is loaded so that the first pop returns a dummy 0 and the next 16 pops return the value MSB first. The decoder then goes back to idle.
- R8: A write frame needs turnaround bits 1 then 0. Any other turnaround abandons the frame and stores nothing.
- R9: A write stores its 16 data bits, MSB first, into the addressed register when the last data bit arrives. A later write to the same register overwrites it.
- R10: A read of register 1 returns 0x0004 when link_up is high and 0x0000 when it is low, whatever was written there.
- R11: Each pop shifts the output register left and fills with zero, so pops beyond the loaded bits return 0.
- R12: Every write strobe stores wr_data into ctl_q, except bit 19 on a pop. ctl_q holds its value when no write occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle strobe: write of the control word |
| wr_data | input | 32 | Control word being written |
| link_up | input | 1 | Link-present indication reported through register 1 |
| ctl_q | output | 32 | Control register image; bit 19 carries popped read data |

## Verification
A table of frames writes several registers at different PHY addresses, including the lowest and highest register numbers, and reads them back through other PHY addresses. This separates correct MSB-first assembly from bit-reversed or misaligned storage, and it shows that the PHY field does not select storage. Directed sequences insert near-miss command words in the middle of a frame, send a long preamble, abort at the start, opcode and turnaround fields, and pop past the end of the loaded data. Each of these shows whether the decoder resynchronises where it should, stores nothing on an aborted frame, and zero-fills the shifter. Register 1 is read with link_up high and then low after a value has been written to it, which shows that the link input takes precedence over the stored contents.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;

    localparam int CTL_W     = 32;
    localparam int BIT_WEN   = 13;
    localparam int BIT_REN   = 14;
    localparam int BIT_CLK   = 16;
    localparam int BIT_TXD   = 17;
    localparam int BIT_MRD   = 18;
    localparam int BIT_RXD   = 19;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 5;
    localparam int LOAD_LSB  = 15;
    localparam int STATUS_REG = 1;
    localparam logic [DATA_W-1:0] LINK_VAL = 16'h0004;

    localparam logic [CTL_W-1:0] FEED_WORD =
        (CTL_W'(1) << BIT_CLK) | (CTL_W'(1) << BIT_WEN);
    localparam logic [CTL_W-1:0] POP_WORD =
        (CTL_W'(1) << BIT_CLK) | (CTL_W'(1) << BIT_REN) | (CTL_W'(1) << BIT_MRD);
    localparam logic [CTL_W-1:0] TXD_MASK = ~(CTL_W'(1) << BIT_TXD);

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_FEED,
        CMD_POP
    } strobe_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SYNC,
        ST_OPC,
        ST_OP_HI,
        ST_OP_LO,
        ST_PHY,
        ST_REG,
        ST_TA_HI,
        ST_TA_LO,
        ST_DATA
    } frame_state_e;

    typedef struct packed {
        logic              fire;
        logic [ADDR_W-1:0] addr;
    } rd_req_t;

    typedef struct packed {
        logic              fire;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic strobe_kind_e classify(input logic [CTL_W-1:0] w);
        logic [CTL_W-1:0] m;
        m = w & TXD_MASK;
        if (m == FEED_WORD)     return CMD_FEED;
        else if (m == POP_WORD) return CMD_POP;
        else                    return CMD_NONE;
    endfunction

endpackage

// File: rtl/mii_strobe_decode.sv
module mii_strobe_decode
    import mii_mgmt_pkg::*;
(
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic             feed,
    output logic             pop,
    output logic             bit_in
);
    strobe_kind_e kind;

    always_comb begin
        kind   = wr_en ? classify(wr_data) : CMD_NONE;
        feed   = (kind == CMD_FEED);
        pop    = (kind == CMD_POP);
        bit_in = wr_data[BIT_TXD];
    end
endmodule

// File: rtl/mii_frame_fsm.sv
module mii_frame_fsm
    import mii_mgmt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    feed,
    input  logic    bit_in,
    output rd_req_t rd_req,
    output wr_req_t wr_req
);
    localparam int CNT_W = $clog2(DW + 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(AW - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DW - 1);

    frame_state_e   state_q, state_n;
    logic           is_rd_q, is_rd_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [AW-1:0]  phy_q, phy_n;
    logic [AW-1:0]  reg_q, reg_n;
    logic [DW-1:0]  data_q, data_n;

    always_comb begin
        state_n = state_q;
        is_rd_n = is_rd_q;
        cnt_n   = cnt_q;
        phy_n   = phy_q;
        reg_n   = reg_q;
        data_n  = data_q;
        rd_req  = '0;
        wr_req  = '0;
        if (feed) begin
            unique case (state_q)
                ST_IDLE: begin
                    state_n = bit_in ? ST_IDLE : ST_SYNC;
                    phy_n   = '0;
                    reg_n   = '0;
                    data_n  = '0;
                end
                ST_SYNC:  state_n = bit_in ? ST_OPC : ST_IDLE;
                ST_OPC:   state_n = bit_in ? ST_OP_HI : ST_OP_LO;
                ST_OP_HI: begin
                    state_n = bit_in ? ST_IDLE : ST_PHY;
                    is_rd_n = 1'b1;
                    cnt_n   = '0;
                end
                ST_OP_LO: begin
                    state_n = bit_in ? ST_PHY : ST_IDLE;
                    is_rd_n = 1'b0;
                    cnt_n   = '0;
                end
                ST_PHY: begin
                    phy_n = {phy_q[AW-2:0], bit_in};
                    cnt_n = cnt_q + 1'b1;
                    if (cnt_q == ADDR_LAST) begin
                        state_n = ST_REG;
                        cnt_n   = '0;
                    end
                end
                ST_REG: begin
                    reg_n = {reg_q[AW-2:0], bit_in};
                    cnt_n = cnt_q + 1'b1;
                    if (cnt_q == ADDR_LAST) begin
                        cnt_n = '0;
                        if (is_rd_q) begin
                            rd_req.fire = 1'b1;
                            rd_req.addr = reg_n;
                            state_n     = ST_IDLE;
                        end else begin
                            state_n = ST_TA_HI;
                        end
                    end
                end
                ST_TA_HI: state_n = bit_in ? ST_TA_LO : ST_IDLE;
                ST_TA_LO: begin
                    state_n = bit_in ? ST_IDLE : ST_DATA;
                    cnt_n   = '0;
                end
                ST_DATA: begin
                    data_n = {data_q[DW-2:0], bit_in};
                    cnt_n  = cnt_q + 1'b1;
                    if (cnt_q == DATA_LAST) begin
                        wr_req.fire = 1'b1;
                        wr_req.addr = reg_q;
                        wr_req.data = data_n;
                        state_n     = ST_IDLE;
                        cnt_n       = '0;
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            is_rd_q <= 1'b0;
            cnt_q   <= '0;
            phy_q   <= '0;
            reg_q   <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_n;
            is_rd_q <= is_rd_n;
            cnt_q   <= cnt_n;
            phy_q   <= phy_n;
            reg_q   <= reg_n;
            data_q  <= data_n;
        end
    end
endmodule

// File: rtl/mii_regfile.sv
module mii_regfile
    import mii_mgmt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int STAT_IDX = STATUS_REG,
    parameter logic [DW-1:0] LINK_WORD = LINK_VAL
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_req_t       wr_req,
    input  logic [AW-1:0] rd_addr,
    input  logic          link_up,
    output logic [DW-1:0] rd_data
);
    localparam int NUM_REGS = 1 << AW;

    logic [DW-1:0]       mem_q [NUM_REGS];
    logic [NUM_REGS-1:0] we;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_we
        assign we[i] = wr_req.fire && (wr_req.addr == AW'(i));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rst)        mem_q[i] <= '0;
            else if (we[i]) mem_q[i] <= wr_req.data;
        end
    end

    always_comb begin
        if (rd_addr == AW'(STAT_IDX)) rd_data = link_up ? LINK_WORD : '0;
        else                          rd_data = mem_q[rd_addr];
    end
endmodule

// File: rtl/mii_out_shifter.sv
module mii_out_shifter
    import mii_mgmt_pkg::*;
#(
    parameter int W  = CTL_W,
    parameter int DW = DATA_W,
    parameter int LSB = LOAD_LSB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          pop,
    output logic [W-1:0]  sh_q
);
    always_ff @(posedge clk) begin
        if (rst)       sh_q <= '0;
        else if (load) sh_q <= W'(load_data) << LSB;
        else if (pop)  sh_q <= {sh_q[W-2:0], 1'b0};
    end
endmodule

// File: rtl/mii_mgmt_slave.sv
module mii_mgmt_slave
    import mii_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             link_up,
    output logic [CTL_W-1:0] ctl_q
);
    logic              feed, pop, bit_in;
    rd_req_t           rd_req;
    wr_req_t           wr_req;
    logic [DATA_W-1:0] rd_data;
    logic [CTL_W-1:0]  sh_q;
    logic              rd_fire;
    logic [ADDR_W-1:0] rd_addr;

    assign rd_fire = rd_req.fire;
    assign rd_addr = rd_req.addr;

    mii_strobe_decode u_dec (
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .feed   (feed),
        .pop    (pop),
        .bit_in (bit_in)
    );

    mii_frame_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .feed  (feed),
        .bit_in(bit_in),
        .rd_req(rd_req),
        .wr_req(wr_req)
    );

    mii_regfile u_rf (
        .clk    (clk),
        .rst    (rst),
        .wr_req (wr_req),
        .rd_addr(rd_addr),
        .link_up(link_up),
        .rd_data(rd_data)
    );

    mii_out_shifter u_sh (
        .clk      (clk),
        .rst      (rst),
        .load     (rd_fire),
        .load_data(rd_data),
        .pop      (pop),
        .sh_q     (sh_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (wr_en) begin
            ctl_q <= wr_data;
            if (pop) ctl_q[BIT_RXD] <= sh_q[CTL_W-1];
        end
    end
endmodule

// File: rtl/mii_mgmt_slave_chk.sv
module mii_mgmt_slave_chk
    import mii_mgmt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [CTL_W-1:0] wr_data,
    input logic             link_up,
    input logic [CTL_W-1:0] ctl_q,
    input logic [CTL_W-1:0] sh_q,
    input logic             rd_fire,
    input logic [ADDR_W-1:0] rd_addr
);
    logic is_pop;
    assign is_pop = wr_en && ((wr_data & TXD_MASK) == POP_WORD);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctl_q == '0 && sh_q == '0));

    assert_image_write_R12: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !is_pop) |=> (ctl_q == $past(wr_data)));

    assert_image_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctl_q));

    assert_pop_bit_R3: assert property (@(posedge clk) disable iff (rst)
        is_pop |=> (ctl_q[BIT_RXD] == $past(sh_q[CTL_W-1])));

    assert_zero_fill_R11: assert property (@(posedge clk) disable iff (rst)
        is_pop |=> (sh_q[0] == 1'b0 && sh_q[CTL_W-1:1] == $past(sh_q[CTL_W-2:0])));

    assert_status_link_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_fire && rd_addr == ADDR_W'(STATUS_REG)) |=>
        (sh_q[LOAD_LSB+DATA_W-1:LOAD_LSB] == ($past(link_up) ? LINK_VAL : '0)
         && !sh_q[CTL_W-1]));
endmodule

bind mii_mgmt_slave mii_mgmt_slave_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .link_up(link_up),
    .ctl_q  (ctl_q),
    .sh_q   (sh_q),
    .rd_fire(rd_fire),
    .rd_addr(rd_addr)
);

// File: tb/tb_mii_mgmt_slave.sv
module tb_mii_mgmt_slave;
    localparam logic [31:0] FEED = 32'h0001_2000;
    localparam logic [31:0] POP  = 32'h0005_4000;
    localparam logic [31:0] TXD  = 32'h0002_0000;
    localparam int NVEC = 11;
    // entry: {rd, phy[4:0], reg[4:0], data/expected[15:0]}
    localparam logic [26:0] VEC [NVEC] = '{
        {1'b1, 5'd0,  5'd9,  16'h0000},
        {1'b0, 5'd0,  5'd0,  16'hA5C3},
        {1'b0, 5'd7,  5'd31, 16'h8001},
        {1'b0, 5'd31, 5'd16, 16'hFFFF},
        {1'b0, 5'd2,  5'd2,  16'h0001},
        {1'b1, 5'd9,  5'd0,  16'hA5C3},
        {1'b1, 5'd0,  5'd31, 16'h8001},
        {1'b1, 5'd4,  5'd16, 16'hFFFF},
        {1'b1, 5'd2,  5'd2,  16'h0001},
        {1'b0, 5'd1,  5'd2,  16'h7E00},
        {1'b1, 5'd30, 5'd2,  16'h7E00}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        link_up = 1'b1;
    logic [31:0] ctl_q;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    mii_mgmt_slave dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .link_up(link_up), .ctl_q(ctl_q)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        wr(FEED | (b ? TXD : 32'h0));
    endtask

    task automatic send_field(input logic [15:0] v, input int width);
        for (int i = width - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic pop_bit(input bit with_txd, output logic b);
        wr(POP | (with_txd ? TXD : 32'h0));
        b = ctl_q[19];
    endtask

    task automatic read_frame(input logic [4:0] phy, input logic [4:0] rg);
        send_field(16'hF, 4);
        send_field(16'b0110, 4);
        send_field({11'd0, phy}, 5);
        send_field({11'd0, rg}, 5);
    endtask

    task automatic write_frame(input logic [4:0] phy, input logic [4:0] rg,
                               input logic [1:0] ta, input logic [15:0] d);
        send_field(16'hF, 4);
        send_field(16'b0101, 4);
        send_field({11'd0, phy}, 5);
        send_field({11'd0, rg}, 5);
        send_field({14'd0, ta}, 2);
        send_field(d, 16);
    endtask

    task automatic read_reg(input logic [4:0] phy, input logic [4:0] rg,
                            output logic [15:0] v);
        logic b;
        read_frame(phy, rg);
        pop_bit(1'b0, b);
        check(b == 1'b0, "R7 dummy leading bit", {31'd0, b}, 32'd0);
        v = '0;
        for (int i = 0; i < 16; i++) begin
            pop_bit(i[0], b);
            v = {v[14:0], b};
        end
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=0x%08h expected=0x%08h", 0, 1);
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic        b;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check(ctl_q == 32'h0, "R1 ctl_q after reset", ctl_q, 32'h0);
        pop_bit(1'b0, b);
        check(b == 1'b0, "R1 empty shifter after reset", {31'd0, b}, 32'd0);

        // Vector table walk: R6 R7 R9 (and R1 for unwritten register)
        for (int k = 0; k < NVEC; k++) begin
            if (VEC[k][26]) begin
                read_reg(VEC[k][25:21], VEC[k][20:16], v);
                check(v == VEC[k][15:0], "R9 R6 table readback", {16'd0, v},
                      {16'd0, VEC[k][15:0]});
            end else begin
                write_frame(VEC[k][25:21], VEC[k][20:16], 2'b10, VEC[k][15:0]);
            end
        end

        // R11: pops past the end return zero
        for (int i = 0; i < 3; i++) begin
            pop_bit(1'b0, b);
            check(b == 1'b0, "R11 extra pop zero", {31'd0, b}, 32'd0);
        end

        // R12 / R3: plain writes store the word, bit 19 as written
        wr(32'hDEAD_BEEF);
        check(ctl_q == 32'hDEAD_BEEF, "R12 image write", ctl_q, 32'hDEAD_BEEF);
        wr(32'h0008_0000);
        check(ctl_q == 32'h0008_0000, "R3 non-pop keeps bit19", ctl_q, 32'h0008_0000);
        repeat (3) @(negedge clk);
        check(ctl_q == 32'h0008_0000, "R12 image hold", ctl_q, 32'h0008_0000);

        // R3: pop with bit 17 set still pops; rest of word stored
        read_frame(5'd0, 5'd31);
        pop_bit(1'b1, b);
        check(ctl_q == (POP | TXD), "R3 pop word image", ctl_q, POP | TXD);
        pop_bit(1'b1, b);
        check(b == 1'b1, "R3 pop returns data MSB", {31'd0, b}, 32'd1);
        for (int i = 0; i < 15; i++) pop_bit(1'b0, b);
        check(b == 1'b1, "R7 data LSB last", {31'd0, b}, 32'd1);

        // R2: near-miss words in the middle of a write frame are ignored
        send_field(16'hF, 4);
        send_field(16'b0101, 4);
        send_field(16'd3, 5);
        wr(FEED | 32'h1);
        send_field(16'd12, 5);
        wr(FEED & ~32'h0001_0000);
        send_field(16'b10, 2);
        send_field(16'h3C, 8);
        wr(FEED | 32'h0004_0000);
        send_field(16'h5A, 8);
        read_reg(5'd3, 5'd12, v);
        check(v == 16'h3C5A, "R2 near-miss strobes ignored", {16'd0, v}, 32'h3C5A);

        // R4: long preamble
        send_field(16'hFFFF, 16);
        send_field(16'hFFFF, 16);
        read_reg(5'd0, 5'd0, v);
        check(v == 16'hA5C3, "R4 long preamble", {16'd0, v}, 32'hA5C3);
        // R4: 0,0 returns to idle
        send_field(16'b00, 2);
        read_reg(5'd0, 5'd0, v);
        check(v == 16'hA5C3, "R4 sync mismatch to idle", {16'd0, v}, 32'hA5C3);

        // R5: invalid opcodes
        send_field(16'b0111, 4);
        read_reg(5'd0, 5'd31, v);
        check(v == 16'h8001, "R5 opcode 11 aborts", {16'd0, v}, 32'h8001);
        send_field(16'b0100, 4);
        read_reg(5'd0, 5'd31, v);
        check(v == 16'h8001, "R5 opcode 00 aborts", {16'd0, v}, 32'h8001);

        // R8: bad turnaround stores nothing
        write_frame(5'd0, 5'd0, 2'b11, 16'hFFFF);
        read_reg(5'd0, 5'd0, v);
        check(v == 16'hA5C3, "R8 bad turnaround no store", {16'd0, v}, 32'hA5C3);

        // R10: status register follows link_up
        write_frame(5'd0, 5'd1, 2'b10, 16'h1234);
        link_up = 1'b1;
        read_reg(5'd5, 5'd1, v);
        check(v == 16'h0004, "R10 link up", {16'd0, v}, 32'h0004);
        link_up = 1'b0;
        read_reg(5'd5, 5'd1, v);
        check(v == 16'h0000, "R10 link down", {16'd0, v}, 32'h0000);

        // R9: overwrite with a new value
        write_frame(5'd8, 5'd16, 2'b10, 16'h0F0F);
        read_reg(5'd8, 5'd16, v);
        check(v == 16'h0F0F, "R9 overwrite", {16'd0, v}, 32'h0F0F);

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule